// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block sits beside a small CPU's instruction sequencer and decides, each time an instruction finishes, whether the sequencer should branch into interrupt processing and, if so, for which source. It keeps a latch for each of four maskable hardware sources and a latch for the software-interrupt instruction. Each latch holds until the sequencer acknowledges that source. The block never interrupts an instruction partway through. A request only counts at the cycle in which the instruction-complete strobe is high.

The four hardware sources are an external interrupt pin, a multi-function timer, a bus interface unit and a sync-signal processor. The global mask bit blocks all of them. The software interrupt ignores the mask. When the mask is clear, hardware requests that were already latched when the software-interrupt instruction was fetched are served before it. Hardware requests that arrive at or after that fetch are served after it. On every take the block also raises a request to set the mask bit, and it supplies the source code and the address of the high byte of that source's vector pair.

Top module: `irq_boundary_arbiter`

## Requirements
- R1: A one-cycle high on `hw_req[k]` latches source k as pending from the next cycle on. A one-cycle high on `swi_fetch` latches the software interrupt as pending from the next cycle on.
- R2: While `i_mask` is 1, no hardware source is taken. Only the software interrupt (code 4) can be taken.
- R3: `take_irq` is high only in a cycle where `insn_done` is high. A pending source gives no take without it.
- R4: In every cycle where `take_irq` is high, `set_imask` is also high. In every other cycle it is low.
- R5: A pending software interrupt is taken at a boundary whether `i_mask` is 0 or 1.
- R6: With `i_mask` 0, hardware sources that were pending when `swi_fetch` was strobed are taken before the software interrupt. They keep their mutual priority order.
- R7: A hardware request that is latched in the same cycle as `swi_fetch` or later is taken only after the software interrupt has been acknowledged, even if its priority is higher.
- R8: Among hardware sources, the lowest bit wins. `src_id` gives 0 for the external pin (bit 0), 1 for the timer (bit 1), 2 for the bus unit (bit 2), 3 for the sync processor (bit 3) and 4 for the software interrupt.
- R9: `vec_addr` is 0x3FFC for the software interrupt. For hardware code k it is 0x3FFA − 2·k, which gives 0x3FFA, 0x3FF8, 0x3FF6 and 0x3FF4.
- R10: A pending latch clears only when that source's own acknowledge is strobed. A request held while masked stays pending across any number of boundaries. An acknowledge for another source does not clear it.
- R11: At a boundary with no software interrupt pending and either the mask set or no hardware source pending, `take_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all pending state |
| hw_req | input | 4 | Hardware request lines, bit 0 highest priority |
| swi_fetch | input | 1 | Strobe: the software-interrupt instruction was fetched |
| i_mask | input | 1 | Current global interrupt mask bit |
| insn_done | input | 1 | Strobe: the current instruction has completed |
| ack_hw | input | 4 | Per-source acknowledge; clears that hardware pending latch |
| ack_swi | input | 1 | Acknowledge for the software interrupt |
| take_irq | output | 1 | Take an interrupt at this boundary |
| set_imask | output | 1 | Request to set the mask bit |
| src_id | output | 3 | Code of the selected source |
| vec_addr | output | 16 | Address of the high byte of the selected vector pair |

## Verification
The assertions check four things on every cycle: takes happen only at boundaries, the mask blocks hardware sources, a pending software interrupt is always taken, and idle boundaries stay idle. They also check that pending latches neither drop without an acknowledge nor miss a request. Only the bench scenarios can show the ordering around a software interrupt: that an early hardware request goes first and a later, higher-priority request waits behind it. Those scenarios also show the exact source codes and vector addresses, and they show that a masked request comes out after many boundaries once the mask clears.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants for the instruction-boundary interrupt arbiter.
// Assumes hardware source k has its vector pair two bytes below source k-1.
package irq_arb_pkg;
    localparam int          VEC_W       = 16;
    localparam logic [15:0] VEC_SWI     = 16'h3FFC;
    localparam logic [15:0] VEC_HW_TOP  = 16'h3FFA;
    localparam int          VEC_STEP    = 2;
endpackage

// File: rtl/irq_pend_bank.sv
// Module: one pending latch per maskable source.
// A request sets the latch and the matching acknowledge clears it. When both
// arrive in the same cycle, the set wins, so a fresh request is never lost.
// Assumes requests and acknowledges are synchronous to clk.
module irq_pend_bank #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] ack,
    output logic [N_SRC-1:0] pend
);
    for (genvar k = 0; k < N_SRC; k++) begin : g_latch
        // Holds source k until its own acknowledge is seen.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[k] <= 1'b0;
            else if (req[k])
                pend[k] <= 1'b1;
            else if (ack[k])
                pend[k] <= 1'b0;
        end

        p_pend_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            req[k] |=> pend[k]);
        p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            pend[k] && !ack[k] |=> pend[k]);
    end
endmodule

// File: rtl/irq_swi_order.sv
// Module: software-interrupt pending flag and the snapshot of the hardware
// sources that were pending when the software interrupt was fetched.
// The snapshot takes the registered pending vector, so a request latched in
// the fetch cycle itself counts as later. An acknowledge removes a bit from
// the snapshot. The software-interrupt acknowledge empties the snapshot.
module irq_swi_order #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swi_fetch,
    input  logic             ack_swi,
    input  logic [N_SRC-1:0] ack_hw,
    input  logic [N_SRC-1:0] pend,
    output logic             swi_pend,
    output logic [N_SRC-1:0] snap
);
    // Software-interrupt pending latch; a fetch beats a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            swi_pend <= 1'b0;
        else if (swi_fetch)
            swi_pend <= 1'b1;
        else if (ack_swi)
            swi_pend <= 1'b0;
    end

    // Records which hardware sources must go before the software interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (swi_fetch)
            snap <= pend & ~ack_hw;
        else if (ack_swi)
            snap <= '0;
        else
            snap <= snap & ~ack_hw;
    end

    // The snapshot only names sources that are still pending.
    p_snap_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snap & ~pend) == '0);
    p_swi_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        swi_fetch |=> swi_pend);
endmodule

// File: rtl/irq_select.sv
// Module: combinational choice made at an instruction boundary.
// Order: first the early hardware sources (only when unmasked), then the
// software interrupt, then any unmasked hardware source. Within a group the
// lowest index wins. Assumes all inputs come from registers or stable inputs.
module irq_select
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int ID_W  = 3
) (
    input  logic             insn_done,
    input  logic             i_mask,
    input  logic             swi_pend,
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] snap,
    output logic             take,
    output logic [ID_W-1:0]  id,
    output logic [VEC_W-1:0] vec
);
    localparam logic [ID_W-1:0] SWI_ID = ID_W'(N_SRC);

    logic [N_SRC-1:0] early;
    logic [N_SRC-1:0] cand;
    logic [ID_W-1:0]  cand_id;
    logic             use_hw;

    // Early sources are those named in the snapshot, and only when unmasked.
    always_comb early = (snap & pend) & {N_SRC{~i_mask}};

    // Picks the group of hardware candidates that is eligible at this boundary.
    always_comb begin
        if (|early)
            cand = early;
        else if (swi_pend)
            cand = '0;
        else
            cand = pend & {N_SRC{~i_mask}};
    end

    // Priority encoder: the lowest set bit gives the source code.
    always_comb begin
        cand_id = '0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (cand[k])
                cand_id = ID_W'(k);
        end
    end

    // Drives the decision, the code and the vector address.
    always_comb begin
        use_hw = |cand;
        take   = insn_done && (use_hw || swi_pend);
        if (use_hw) begin
            id  = cand_id;
            vec = VEC_HW_TOP - VEC_W'(VEC_STEP) * VEC_W'(cand_id);
        end else begin
            id  = SWI_ID;
            vec = VEC_SWI;
        end
    end
endmodule

// File: rtl/irq_boundary_arbiter.sv
// Module: top of the instruction-boundary interrupt arbiter.
// Latches four maskable sources and the software interrupt. At each
// instruction-complete strobe it tells the sequencer whether to take an
// interrupt, which one, and where its vector lives. Assumes the sequencer
// acknowledges the chosen source once it has fetched the vector.
module irq_boundary_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_HW = 4,
    parameter int ID_W = $clog2(N_HW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_HW-1:0]  hw_req,
    input  logic             swi_fetch,
    input  logic             i_mask,
    input  logic             insn_done,
    input  logic [N_HW-1:0]  ack_hw,
    input  logic             ack_swi,
    output logic             take_irq,
    output logic             set_imask,
    output logic [ID_W-1:0]  src_id,
    output logic [15:0]      vec_addr
);
    localparam logic [ID_W-1:0] SWI_ID = ID_W'(N_HW);

    logic [N_HW-1:0] pend;
    logic [N_HW-1:0] snap;
    logic            swi_pend;

    irq_pend_bank #(.N_SRC(N_HW)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (hw_req),
        .ack  (ack_hw),
        .pend (pend)
    );

    irq_swi_order #(.N_SRC(N_HW)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .swi_fetch(swi_fetch),
        .ack_swi  (ack_swi),
        .ack_hw   (ack_hw),
        .pend     (pend),
        .swi_pend (swi_pend),
        .snap     (snap)
    );

    irq_select #(.N_SRC(N_HW), .ID_W(ID_W)) u_sel (
        .insn_done(insn_done),
        .i_mask   (i_mask),
        .swi_pend (swi_pend),
        .pend     (pend),
        .snap     (snap),
        .take     (take_irq),
        .id       (src_id),
        .vec      (vec_addr)
    );

    // Every take also blocks further maskable interrupts.
    always_comb set_imask = take_irq;

    p_boundary_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |-> !take_irq);
    p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq && i_mask |-> src_id == SWI_ID);
    p_swi_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && swi_pend && i_mask |-> take_irq && src_id == SWI_ID);
    p_swi_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && swi_pend && (snap & pend) == '0 |-> take_irq && src_id == SWI_ID);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done && !swi_pend && (i_mask || pend == '0) |-> !take_irq);
    p_vec_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !vec_addr[0]);
endmodule

// File: tb/irq_boundary_arbiter_tb.sv
module irq_boundary_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hw_req = '0;
    logic        swi_fetch = 1'b0;
    logic        i_mask = 1'b0;
    logic        insn_done = 1'b0;
    logic [3:0]  ack_hw = '0;
    logic        ack_swi = 1'b0;
    logic        take_irq;
    logic        set_imask;
    logic [2:0]  src_id;
    logic [15:0] vec_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irq_boundary_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .swi_fetch(swi_fetch),
        .i_mask(i_mask), .insn_done(insn_done), .ack_hw(ack_hw), .ack_swi(ack_swi),
        .take_irq(take_irq), .set_imask(set_imask), .src_id(src_id), .vec_addr(vec_addr)
    );

    // Vector entry: {hw pattern[3:0], mask, swi, exp_take, exp_id[2:0]}
    localparam int NV = 10;
    localparam logic [9:0] VT [NV] = '{
        {4'b0000, 1'b0, 1'b0, 1'b0, 3'd0},
        {4'b0001, 1'b0, 1'b0, 1'b1, 3'd0},
        {4'b0110, 1'b0, 1'b0, 1'b1, 3'd1},
        {4'b1100, 1'b0, 1'b0, 1'b1, 3'd2},
        {4'b1000, 1'b0, 1'b0, 1'b1, 3'd3},
        {4'b1111, 1'b1, 1'b0, 1'b0, 3'd0},
        {4'b0000, 1'b1, 1'b1, 1'b1, 3'd4},
        {4'b1010, 1'b1, 1'b1, 1'b1, 3'd4},
        {4'b0100, 1'b0, 1'b1, 1'b1, 3'd2},
        {4'b0000, 1'b0, 1'b1, 1'b1, 3'd4}
    };

    function automatic logic [15:0] exp_vec(input logic [2:0] id);
        return (id == 3'd4) ? 16'h3FFC : 16'h3FFA - 16'(2 * id);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hw_req = '0; swi_fetch = 0; ack_hw = '0; ack_swi = 0;
        insn_done = 0; i_mask = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_hw(input logic [3:0] m);
        hw_req = m; @(negedge clk); hw_req = '0;
    endtask

    task automatic pulse_swi();
        swi_fetch = 1; @(negedge clk); swi_fetch = 0;
    endtask

    task automatic pulse_ack(input logic [3:0] m, input logic s);
        ack_hw = m; ack_swi = s; @(negedge clk); ack_hw = '0; ack_swi = 0;
    endtask

    // Boundary with full check of take, code, vector and mask-set request.
    task automatic boundary(input logic mask, input logic e_take, input logic [2:0] e_id,
                            input string req);
        i_mask = mask; insn_done = 1; #1;
        chk(take_irq == e_take, req, take_irq, e_take);
        chk(set_imask == e_take, {req, "/R4"}, set_imask, e_take);
        if (e_take) begin
            chk(src_id == e_id, {req, "/R8"}, src_id, e_id);
            chk(vec_addr == exp_vec(e_id), {req, "/R9"}, vec_addr, exp_vec(e_id));
        end
        @(negedge clk); insn_done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Reset state
        @(negedge clk); #1;
        chk(take_irq == 0, "R3 reset", take_irq, 0);
        do_reset();
        #1 chk(take_irq == 0 && set_imask == 0, "R11 reset idle", take_irq, 0);
        @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            do_reset();
            @(negedge clk);
            if (VT[i][9:6] != 0) pulse_hw(VT[i][9:6]);
            if (VT[i][4]) pulse_swi();
            boundary(VT[i][5], VT[i][3], VT[i][2:0], $sformatf("R1/R2/R5 vec%0d", i));
        end

        // R3: pending but no boundary
        do_reset(); @(negedge clk);
        pulse_hw(4'b0001);
        #1 chk(take_irq == 0, "R3 no strobe", take_irq, 0);
        @(negedge clk);

        // R10: held while masked over boundaries, foreign ack ignored
        do_reset(); @(negedge clk);
        pulse_hw(4'b0100);
        for (int j = 0; j < 5; j++) boundary(1'b1, 1'b0, 3'd0, "R10 masked hold");
        pulse_ack(4'b1011, 1'b1);
        boundary(1'b0, 1'b1, 3'd2, "R10 after foreign ack");
        pulse_ack(4'b0100, 1'b0);
        boundary(1'b0, 1'b0, 3'd0, "R10 own ack clears");

        // R7: later higher-priority request waits behind software interrupt
        do_reset(); @(negedge clk);
        pulse_swi();
        pulse_hw(4'b0001);
        boundary(1'b0, 1'b1, 3'd4, "R7 swi first");
        pulse_ack(4'b0000, 1'b1);
        boundary(1'b0, 1'b1, 3'd0, "R7 late hw after swi");

        // R7: request in same cycle as the fetch counts as later
        do_reset(); @(negedge clk);
        hw_req = 4'b0010; swi_fetch = 1; @(negedge clk); hw_req = '0; swi_fetch = 0;
        boundary(1'b0, 1'b1, 3'd4, "R7 same-cycle");

        // R6: early timer first, then swi, then late pin
        do_reset(); @(negedge clk);
        pulse_hw(4'b1010);
        pulse_swi();
        pulse_hw(4'b0001);
        boundary(1'b0, 1'b1, 3'd1, "R6 early first");
        pulse_ack(4'b0010, 1'b0);
        boundary(1'b0, 1'b1, 3'd3, "R6 early second");
        pulse_ack(4'b1000, 1'b0);
        boundary(1'b0, 1'b1, 3'd4, "R6 swi after early");
        pulse_ack(4'b0000, 1'b1);
        boundary(1'b0, 1'b1, 3'd0, "R6 late pin");

        // R5: early sources ignored when masked, swi still taken
        do_reset(); @(negedge clk);
        pulse_hw(4'b0001);
        pulse_swi();
        boundary(1'b1, 1'b1, 3'd4, "R5 masked swi");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule